// File: doc/BRIEF.md
# Signed-Digit Divisor Multiple Generator

This block forms the divisor multiple that a radix-4 digit-recurrence divider adds into its carry-save residual each iteration. The next quotient digit, drawn from {-2,-1,0,1,2}, arrives as four one-hot select lines. An all-low word means digit zero. The divisor is an unsigned fraction of `DIV_W` bits. The block returns the two's-complement of `-q·d` as a bit vector one bit wider than the divisor. For positive digits it also returns a separate carry bit that the downstream adder injects at its least significant position.

No adder is used. The doubled divisor is a one-position left shift. Each output bit is an AND-OR of the aligned or doubled divisor bit under the four selects. For positive digits the selected operand is inverted, and the carry bit completes the negation inside the residual adder. The block is purely combinational. The state machine, registers, residual adder and digit selection that surround it live elsewhere.

Top module: `sd_multiple_gen`

## Requirements
- R1: With only `sel_neg1` high (digit -1), `multiple` equals the divisor zero-extended by one bit at the top, and `carry_in` is 0.
- R2: With only `sel_neg2` high (digit -2), `multiple` equals the divisor shifted left one place with a 0 in bit 0, and `carry_in` is 0.
- R3: With only `sel_pos1` high (digit +1), `multiple` equals the bitwise complement of the zero-extended divisor, and `carry_in` is 1.
- R4: With only `sel_pos2` high (digit +2), `multiple` equals the bitwise complement of the left-shifted divisor, so bit 0 is 1, and `carry_in` is 1.
- R5: With all four selects low (digit 0), `multiple` is all zeros and `carry_in` is 0. A word with two or more selects high is illegal, and the outputs are then undefined.
- R6: For every legal digit q and every divisor d, `multiple + carry_in` equals `-q·d` modulo 2^(DIV_W+1).
- R7: `carry_in` is 1 exactly when `sel_pos1` or `sel_pos2` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_neg2 | input | 1 | Digit is -2 |
| sel_neg1 | input | 1 | Digit is -1 |
| sel_pos1 | input | 1 | Digit is +1 |
| sel_pos2 | input | 1 | Digit is +2 |
| divisor | input | DIV_W | Unsigned fractional divisor |
| multiple | output | DIV_W+1 | Two's-complement multiple, complemented for positive digits |
| carry_in | output | 1 | LSB carry that completes negation downstream |

## Verification
Whenever the inputs are known, the checker tests four things: the arithmetic identity of R6, that the carry follows the digit sign (R7), that a zero digit gives a zero output (R5), and that the select word is one-hot or empty.

The bench compares the exact bit pattern for each digit (R1–R4) at the divisor extremes and on random divisors. Only those scenarios can show that the bit-level form is right. A wrong shift that happened to preserve the sum for some values would not be exposed by the identity check.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
package sdm_pkg;
    // Select word, one line per nonzero quotient digit.
    typedef struct packed {
        logic neg2;
        logic neg1;
        logic pos1;
        logic pos2;
    } digit_sel_t;
endpackage

// File: rtl/sdm_operand_align.sv
`timescale 1ns/1ps
module sdm_operand_align #(
    parameter int DIV_W = 16,
    localparam int OUT_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0] divisor,
    output logic [OUT_W-1:0] single_op,
    output logic [OUT_W-1:0] double_op
);
    // Single: zero-extended; double: left shift by one place.
    always_comb begin
        single_op = {1'b0, divisor};
        double_op = {divisor, 1'b0};
    end
endmodule

// File: rtl/sdm_bit_cell.sv
`timescale 1ns/1ps
module sdm_bit_cell
    import sdm_pkg::*;
(
    input  digit_sel_t sel,
    input  logic       single_bit,
    input  logic       double_bit,
    output logic       out_bit
);
    // Pure gating: direct for negative digits, inverted for positive ones.
    always_comb begin
        out_bit = (sel.neg1 &  single_bit)
                | (sel.neg2 &  double_bit)
                | (sel.pos1 & ~single_bit)
                | (sel.pos2 & ~double_bit);
    end
endmodule

// File: rtl/sd_multiple_gen.sv
`timescale 1ns/1ps
module sd_multiple_gen
    import sdm_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int OUT_W = DIV_W + 1
) (
    input  logic             sel_neg2,
    input  logic             sel_neg1,
    input  logic             sel_pos1,
    input  logic             sel_pos2,
    input  logic [DIV_W-1:0] divisor,
    output logic [DIV_W:0]   multiple,
    output logic             carry_in
);
    digit_sel_t       sel;
    logic [OUT_W-1:0] single_op;
    logic [OUT_W-1:0] double_op;

    always_comb begin
        sel.neg2 = sel_neg2;
        sel.neg1 = sel_neg1;
        sel.pos1 = sel_pos1;
        sel.pos2 = sel_pos2;
    end

    sdm_operand_align #(.DIV_W(DIV_W)) u_align (
        .divisor   (divisor),
        .single_op (single_op),
        .double_op (double_op)
    );

    for (genvar i = 0; i < OUT_W; i++) begin : g_cell
        sdm_bit_cell u_cell (
            .sel        (sel),
            .single_bit (single_op[i]),
            .double_bit (double_op[i]),
            .out_bit    (multiple[i])
        );
    end

    // Positive digit: the output is a one's complement; the +1 is deferred.
    always_comb carry_in = sel.pos1 | sel.pos2;
endmodule

// File: rtl/sd_multiple_gen_chk.sv
`timescale 1ns/1ps
module sd_multiple_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             sel_neg2,
    input logic             sel_neg1,
    input logic             sel_pos1,
    input logic             sel_pos2,
    input logic [DIV_W-1:0] divisor,
    input logic [DIV_W:0]   multiple,
    input logic             carry_in
);
    logic [DIV_W:0] sum;
    logic [DIV_W:0] want;
    logic [DIV_W:0] d_ext;

    always_comb begin
        d_ext = {1'b0, divisor};
        sum   = multiple + {{DIV_W{1'b0}}, carry_in};
        if (sel_pos2)      want = -(d_ext << 1);
        else if (sel_pos1) want = -d_ext;
        else if (sel_neg1) want = d_ext;
        else if (sel_neg2) want = d_ext << 1;
        else               want = '0;
    end

    always_comb begin
        if (!$isunknown({sel_neg2, sel_neg1, sel_pos1, sel_pos2, divisor})) begin
            // R5: select word must be one-hot or empty
            a_r5_sel_onehot0: assert ($onehot0({sel_neg2, sel_neg1, sel_pos1, sel_pos2}))
                else $error("illegal select word");
            if ($onehot0({sel_neg2, sel_neg1, sel_pos1, sel_pos2})) begin
                a_r6_negated_product: assert (sum == want)
                    else $error("multiple+carry != -q*d");
                a_r7_carry_sign: assert (carry_in == (sel_pos1 | sel_pos2))
                    else $error("carry does not follow digit sign");
                a_r5_zero_digit: assert ((sel_neg2 | sel_neg1 | sel_pos1 | sel_pos2) || (multiple == '0 && !carry_in))
                    else $error("zero digit gave nonzero output");
            end
        end
    end
endmodule

bind sd_multiple_gen sd_multiple_gen_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sd_multiple_gen_test.sv
`timescale 1ns/1ps
module sd_multiple_gen_test;
    localparam int W = 16;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         sel_neg2, sel_neg1, sel_pos1, sel_pos2;
    logic [W-1:0] divisor;
    logic [W:0]   multiple;
    logic         carry_in;
    int           checks = 0;
    int           fails = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    sd_multiple_gen #(.DIV_W(W)) uut (
        .sel_neg2 (sel_neg2),
        .sel_neg1 (sel_neg1),
        .sel_pos1 (sel_pos1),
        .sel_pos2 (sel_pos2),
        .divisor  (divisor),
        .multiple (multiple),
        .carry_in (carry_in)
    );

    function automatic logic [W:0] exp_mult(int dig, logic [W-1:0] d);
        longint p = longint'(dig) * longint'(d);
        if (dig > 0) return ~p[W:0];
        return -p[W:0];
    endfunction

    function automatic logic [W:0] exp_sum(int dig, logic [W-1:0] d);
        longint p = -(longint'(dig) * longint'(d));
        return p[W:0];
    endfunction

    function automatic string req_of(int dig);
        case (dig)
            -1: return "R1";
            -2: return "R2";
             1: return "R3";
             2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [W:0] got, logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(int dig, logic [W-1:0] d);
        logic [W:0] s;
        @(negedge clk);
        sel_neg2 = (dig == -2);
        sel_neg1 = (dig == -1);
        sel_pos1 = (dig == 1);
        sel_pos2 = (dig == 2);
        divisor  = d;
        #5;
        check(req_of(dig), multiple, exp_mult(dig, d));
        check("R7", {{W{1'b0}}, carry_in}, {{W{1'b0}}, (dig > 0)});
        s = multiple + {{W{1'b0}}, carry_in};
        check("R6", s, exp_sum(dig, d));
    endtask

    initial begin
        logic [W-1:0] corners [4];
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = 1;
        corners[3] = {1'b1, {(W-1){1'b0}}};
        sel_neg2 = 0; sel_neg1 = 0; sel_pos1 = 0; sel_pos2 = 0;
        divisor = '0;
        repeat (2) @(posedge clk);
        rst_n = 1;
        // Reset/idle state: zero digit gives zero output (R5)
        @(negedge clk);
        check("R5", multiple, '0);
        check("R5", {{W{1'b0}}, carry_in}, '0);
        void'($urandom(32'h5EED_0042));
        for (int c = 0; c < 4; c++)
            for (int dg = -2; dg <= 2; dg++)
                apply(dg, corners[c]);
        for (int n = 0; n < 500; n++) begin
            int dg = int'($urandom_range(4)) - 2;
            apply(dg, W'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule